// File: doc/BRIEF.md
# Port Bit Pattern-Match Detector

This block watches a parallel input port and raises a match event when the port shows a programmed pattern. Each port bit first passes through a polarity stage that can invert it. Three per-bit configuration vectors then give each bit its own condition. The condition can be ignore, a steady low or high level, a rising or falling edge, or any change. Edges are judged against the sample taken one clock earlier.

The per-bit results are combined in one of four ways, chosen by a two-bit mode: no matching, all unmasked bits together (AND), any unmasked bit (OR), or any bit with a priority code (OR-priority). In OR-priority mode the number of the highest matching bit is kept for building an interrupt vector, with bit W-1 having the top priority. A sticky flag records that a match has occurred. An optional capture register keeps the corrected port sample that caused the match.

Top module: `pmatch_detector`

## Requirements
- R1: The sample used for matching is `port_in ^ pol_inv`. A 1 in `pol_inv` inverts that bit.
- R2: Each bit's condition is set by {`pat_mask`,`pat_trans`}. 00 ignores the bit. 01 matches any change. 10 matches a level equal to `pat_pol`. 11 matches an edge toward `pat_pol`: 1 means rising, 0 means falling. A bit is unmasked when either of its mask or transition bits is 1.
- R3: Edge and change conditions compare the current sample with the sample taken one clock earlier. After reset, a level condition can hold once one sample has been taken. An edge or change condition can hold only after two samples.
- R4: `pm_mode` encodes 0 none, 1 AND, 2 OR, 3 OR-priority. In none mode there is never a match. In AND mode there is a match only when at least one bit is unmasked and every unmasked bit holds in the same cycle. In OR mode there is a match when any unmasked bit holds.
- R5: OR-priority mode matches exactly as OR mode does. On each match in this mode, `prio_code` loads the index of the highest-numbered bit that holds. At all other times `prio_code` keeps its value.
- R6: `hit` is high for exactly one cycle per matching sample. Sample a value into the block at a clock edge; `hit` then shows the result for that value after the next edge.
- R7: `match_flag` is set by every `hit` and stays set. It clears at the edge where `clr_flag` is high and no new match occurs. A new match wins over a clear.
- R8: When a match occurs while `latch_en` is high, `latched_data` takes the polarity-corrected sample that matched. Otherwise it keeps its value.
- R9: Synchronous reset clears `hit`, `match_flag`, `latched_data`, `prio_code` and the sample history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | W | Raw port data |
| pol_inv | input | W | Per-bit inversion select |
| pat_pol | input | W | Per-bit target level or edge direction |
| pat_trans | input | W | Per-bit edge/change select |
| pat_mask | input | W | Per-bit condition enable |
| pm_mode | input | 2 | Combine mode: 0 none, 1 AND, 2 OR, 3 OR-priority |
| latch_en | input | 1 | Capture the sample on a match |
| clr_flag | input | 1 | Clear the sticky match flag |
| hit | output | 1 | One-cycle match event |
| match_flag | output | 1 | Sticky match flag |
| latched_data | output | W | Captured corrected sample |
| prio_code | output | $clog2(W) | Highest matching bit number |

## Verification
The hardest situation to reach is an AND match that mixes edge and level bits. The edge must arrive on exactly the clock where every level bit already holds, and in the first two samples after reset edge bits must stay silent. The stimulus gets there with directed edge sequences that begin right after reset, and with many random cycles that draw a fresh configuration and port value on every clock. A bench model of the sample history follows every cycle. A clear request that lands on the same clock as a new match happens often in the random cycles, so the rule that a new match wins over a clear is exercised there.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_AND  = 2'd1,
    PM_OR   = 2'd2,
    PM_PRIO = 2'd3
  } pm_mode_e;
endpackage

// File: rtl/pm_sampler.sv
module pm_sampler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] port_in,
  input  logic [W-1:0] pol_inv,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev,
  output logic         lvl_ok,
  output logic         edge_ok
);
  logic [1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      prev <= '0;
      vld  <= '0;
    end else begin
      cur  <= port_in ^ pol_inv;
      prev <= cur;
      vld  <= {vld[0], 1'b1};
    end
  end

  assign lvl_ok  = vld[0];
  assign edge_ok = vld[1];

  // R3: edge history is never valid before a level sample exists
  a_r3_history_order: assert property (@(posedge clk) disable iff (rst)
    edge_ok |-> lvl_ok);
endmodule

// File: rtl/pm_bitcond.sv
module pm_bitcond #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic         lvl_ok,
  input  logic         edge_ok,
  input  logic [W-1:0] pat_pol,
  input  logic [W-1:0] pat_trans,
  input  logic [W-1:0] pat_mask,
  output logic [W-1:0] sat,
  output logic [W-1:0] active
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic chg;
    assign chg       = cur[i] ^ prev[i];
    assign active[i] = pat_mask[i] | pat_trans[i];
    always_comb begin
      case ({pat_mask[i], pat_trans[i]})
        2'b00:   sat[i] = 1'b0;
        2'b01:   sat[i] = edge_ok & chg;
        2'b10:   sat[i] = lvl_ok & (cur[i] == pat_pol[i]);
        default: sat[i] = edge_ok & chg & (cur[i] == pat_pol[i]);
      endcase
    end
  end
endmodule

// File: rtl/pm_combine.sv
module pm_combine
  import pm_pkg::*;
#(
  parameter int W = 8,
  localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]    sat,
  input  logic [W-1:0]    active,
  input  pm_mode_e        mode,
  output logic            match,
  output logic [IDXW-1:0] code
);
  logic any_hit, all_hit;

  assign any_hit = |(sat & active);
  assign all_hit = (|active) & (&(sat | ~active));

  always_comb begin
    case (mode)
      PM_AND:  match = all_hit;
      PM_OR,
      PM_PRIO: match = any_hit;
      default: match = 1'b0;
    endcase
  end

  // Ascending scan: the last hit seen is the highest index
  always_comb begin
    code = '0;
    for (int i = 0; i < W; i++)
      if (sat[i] && active[i]) code = IDXW'(i);
  end
endmodule

// File: rtl/pmatch_detector.sv
module pmatch_detector
  import pm_pkg::*;
#(
  parameter int W = 8,
  localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    port_in,
  input  logic [W-1:0]    pol_inv,
  input  logic [W-1:0]    pat_pol,
  input  logic [W-1:0]    pat_trans,
  input  logic [W-1:0]    pat_mask,
  input  logic [1:0]      pm_mode,
  input  logic            latch_en,
  input  logic            clr_flag,
  output logic            hit,
  output logic            match_flag,
  output logic [W-1:0]    latched_data,
  output logic [IDXW-1:0] prio_code
);
  logic [W-1:0]    cur, prev, sat, active;
  logic            lvl_ok, edge_ok, match;
  logic [IDXW-1:0] code;
  pm_mode_e        mode;

  assign mode = pm_mode_e'(pm_mode);

  pm_sampler #(.W(W)) u_smp (
    .clk(clk), .rst(rst), .port_in(port_in), .pol_inv(pol_inv),
    .cur(cur), .prev(prev), .lvl_ok(lvl_ok), .edge_ok(edge_ok)
  );

  pm_bitcond #(.W(W)) u_cond (
    .cur(cur), .prev(prev), .lvl_ok(lvl_ok), .edge_ok(edge_ok),
    .pat_pol(pat_pol), .pat_trans(pat_trans), .pat_mask(pat_mask),
    .sat(sat), .active(active)
  );

  pm_combine #(.W(W)) u_comb (
    .sat(sat), .active(active), .mode(mode), .match(match), .code(code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit          <= 1'b0;
      match_flag   <= 1'b0;
      latched_data <= '0;
      prio_code    <= '0;
    end else begin
      hit <= match;
      if (match)         match_flag <= 1'b1;
      else if (clr_flag) match_flag <= 1'b0;
      if (match && latch_en)          latched_data <= cur;
      if (match && mode == PM_PRIO)   prio_code    <= code;
    end
  end

  // R4: no match event while combining is off
  a_r4_none_quiet: assert property (@(posedge clk) disable iff (rst)
    (pm_mode == 2'd0) |=> !hit);
  // R7: a match event always leaves the flag set
  a_r7_flag_on_hit: assert property (@(posedge clk) disable iff (rst)
    hit |-> match_flag);
  // R7: the flag only falls after a clear request
  a_r7_flag_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(match_flag) |-> $past(clr_flag));
  // R8: captured data moves only on a match with capture enabled
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(latched_data) |-> (hit && $past(latch_en)));
  // R5: priority code moves only on a priority-mode match
  a_r5_code_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(prio_code) |-> (hit && $past(pm_mode) == 2'd3));
endmodule

// File: tb/pmatch_detector_test.sv
`timescale 1ns/1ps
module pmatch_detector_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] port_in, pol_inv, pat_pol, pat_trans, pat_mask;
  logic [1:0] pm_mode;
  logic latch_en, clr_flag;
  logic hit, match_flag;
  logic [W-1:0] latched_data;
  logic [2:0] prio_code;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [W-1:0] m_cur, m_prev;
  int m_n;
  logic e_flag;
  logic [W-1:0] e_lat;
  logic [2:0] e_prio;

  always #4 clk = ~clk;

  pmatch_detector #(.W(W)) uut (
    .clk(clk), .rst(rst), .port_in(port_in), .pol_inv(pol_inv),
    .pat_pol(pat_pol), .pat_trans(pat_trans), .pat_mask(pat_mask),
    .pm_mode(pm_mode), .latch_en(latch_en), .clr_flag(clr_flag),
    .hit(hit), .match_flag(match_flag), .latched_data(latched_data),
    .prio_code(prio_code)
  );

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Condition of one bit from the requirement table (R2, R3)
  function automatic logic bit_ok(input int i);
    logic c, l;
    c = m_cur[i] ^ m_prev[i];
    l = (m_cur[i] == pat_pol[i]);
    case ({pat_mask[i], pat_trans[i]})
      2'b00: return 1'b0;
      2'b01: return (m_n >= 2) && c;
      2'b10: return (m_n >= 1) && l;
      default: return (m_n >= 2) && c && l;
    endcase
  endfunction

  function automatic logic exp_match();
    logic any, all, act;
    any = 0; all = 1; act = 0;
    for (int i = 0; i < W; i++) begin
      if (pat_mask[i] | pat_trans[i]) begin
        act = 1;
        if (bit_ok(i)) any = 1; else all = 0;
      end
    end
    case (pm_mode)
      2'd1: return act && all;
      2'd2, 2'd3: return any;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] exp_code();
    logic [2:0] c;
    c = 0;
    for (int i = 0; i < W; i++) if (bit_ok(i)) c = 3'(i);
    return c;
  endfunction

  task automatic step(input logic [W-1:0] v, input string rq);
    logic m;
    @(negedge clk);
    port_in = v;
    @(posedge clk);
    #1;
    m = exp_match();
    if (m) e_flag = 1'b1; else if (clr_flag) e_flag = 1'b0;
    if (m && latch_en) e_lat = m_cur;
    if (m && pm_mode == 2'd3) e_prio = exp_code();
    check(rq, "hit", hit, m);
    check("R7", "match_flag", match_flag, e_flag);
    check("R8", "latched_data", latched_data, e_lat);
    check("R5", "prio_code", prio_code, e_prio);
    m_prev = m_cur;
    m_cur = v ^ pol_inv;
    if (m_n < 2) m_n++;
  endtask

  task automatic cfg(input logic [W-1:0] pp, input logic [W-1:0] pt,
                     input logic [W-1:0] pm, input logic [1:0] md);
    pat_pol = pp; pat_trans = pt; pat_mask = pm; pm_mode = md;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    m_cur = 0; m_prev = 0; m_n = 0;
    e_flag = 0; e_lat = 0; e_prio = 0;
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    port_in = 0; pol_inv = 0; latch_en = 0; clr_flag = 0;
    cfg(8'h00, 8'h00, 8'h00, 2'd0);
    do_reset();
    // R9: everything cleared by reset
    check("R9", "hit", hit, 0);
    check("R9", "match_flag", match_flag, 0);
    check("R9", "latched_data", latched_data, 0);
    check("R9", "prio_code", prio_code, 0);

    // R3: level and edge bits right after reset; edge silent for two samples
    cfg(8'h01, 8'h10, 8'h01, 2'd1);          // bit0 level 1, bit4 any change
    step(8'h11, "R3"); step(8'h01, "R3"); step(8'h11, "R3");
    check("R3", "hit after change", hit, 1);

    // R2/R4: AND of levels, mismatch then match
    cfg(8'h01, 8'h00, 8'h03, 2'd1);          // bit0 must be 1, bit1 must be 0
    step(8'h03, "R4"); step(8'h01, "R4"); step(8'h01, "R4");
    check("R4", "AND level hit", hit, 1);
    cfg(8'h00, 8'h00, 8'h00, 2'd1);          // all masked: AND never matches
    step(8'hff, "R4"); step(8'h00, "R4");
    check("R4", "AND all masked", hit, 0);

    // R2: rising edge on bit4, then falling edge on bit4
    cfg(8'h10, 8'h10, 8'h10, 2'd2);
    step(8'h00, "R2"); step(8'h10, "R2"); step(8'h10, "R2");
    check("R2", "rising edge", hit, 1);
    step(8'h10, "R2");
    check("R2", "no edge", hit, 0);
    cfg(8'h00, 8'h10, 8'h10, 2'd2);
    step(8'h00, "R2"); step(8'h00, "R2");
    check("R2", "falling edge", hit, 1);

    // R1: inverted bit0 matches level 1 with a low pin
    clr_flag = 1; pol_inv = 8'h01;
    cfg(8'h01, 8'h00, 8'h01, 2'd2);
    step(8'h00, "R1"); step(8'h00, "R1");
    check("R1", "inverted level", hit, 1);
    clr_flag = 0; pol_inv = 8'h00;

    // R5/R8: priority code and capture
    latch_en = 1;
    cfg(8'hff, 8'h00, 8'hff, 2'd3);
    step(8'h24, "R5"); step(8'h81, "R5");
    check("R5", "code for bits 5,2", prio_code, 5);
    check("R8", "capture", latched_data, 8'h24);
    step(8'h00, "R5");
    check("R5", "code for bits 7,0", prio_code, 7);
    latch_en = 0;

    // R4/R7: none mode, then a clear with no match
    cfg(8'hff, 8'h00, 8'hff, 2'd0);
    step(8'hff, "R4"); step(8'hff, "R4");
    check("R4", "none mode", hit, 0);
    clr_flag = 1;
    step(8'hff, "R7"); clr_flag = 0; step(8'hff, "R7");
    check("R7", "flag cleared", match_flag, 0);

    // R6: random configurations and data every cycle
    for (int k = 0; k < 3000; k++) begin
      pol_inv   = 8'($urandom);
      pat_pol   = 8'($urandom);
      pat_trans = 8'($urandom) & 8'($urandom);
      pat_mask  = 8'($urandom) & 8'($urandom);
      pm_mode   = 2'($urandom);
      latch_en  = 1'($urandom);
      clr_flag  = ($urandom % 4) == 0;
      step(8'($urandom), "R6");
    end

    // R9: reset again clears state mid-run
    do_reset();
    check("R9", "flag after reset", match_flag, 0);
    check("R9", "code after reset", prio_code, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule